// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers of a message signalled interrupt capability for one PCI function. Software reaches it through a config port that gives a byte offset relative to the capability base, a 4-bit byte enable and a single-cycle write strobe. Reads are combinational from the offset. Three parameters set the register layout: the supported vector count (a power of two from 1 to 32), whether the message address is 64 bits wide, and whether per-vector masking is present.

The stored state goes to a message dispatcher elsewhere in the function. The dispatcher gets the enable bit, the allocated vector count, the message address and data, and the mask and pending vectors. The dispatcher marks vectors pending when they fire while masked, and clears them when it delivers them. Linking into the capability list and legacy pin interrupts are handled outside this block.

Top module: `msi_cap_regs`

## Requirements
- R1: Registers are selected by dword index cfg_off_i[7:2], and bits [1:0] of the offset are ignored. Index 0 is the control word in bits [31:16]: bit 16 is enable, [19:17] is log2 of the supported count, [22:20] is log2 of the enabled count, bit 23 is the 64-bit flag and bit 24 is the mask flag. Bits [15:0] read zero. Index 1 is the low address. With the 64-bit option, index 2 is the high address, 3 is data, 4 is mask and 5 is pending. Without it, index 2 is data, 3 is mask and 4 is pending.
- R2: The capability is 0x0A bytes long for 32-bit without masking, 0x0E for 64-bit without masking, 0x14 for 32-bit with masking and 0x18 for 64-bit with masking. A read of any dword index at or beyond the rounded-up end returns zero.
- R3: In the control word only the enable bit and the enabled-count field are writable, and only when byte enable 2 is set. The supported-count field, the 64-bit flag and the mask flag are read-only and follow the parameters.
- R4: If a write to the enabled-count field exceeds the supported-count value, the supported-count value is stored instead.
- R5: Low address bits [1:0] always read zero. The high address is fully writable only with the 64-bit option. Otherwise msg_addr_o[63:32] stays zero.
- R6: Data is a 16-bit register in bits [15:0] of its dword. Bits [31:16] read zero.
- R7: With masking present, only the low NUM_VEC bits of the mask are writable. Without masking, mask and pending read zero and their outputs stay zero.
- R8: Pending is read-only from the config port, and config writes to it are ignored. Pending bit v is set by pend_set_i[v] when v is below the allocated count, and cleared by pend_clr_i[v]. Set wins when both are asserted in the same cycle.
- R9: Pending bits at or above the allocated count are discarded one cycle after that count is in effect.
- R10: Reset clears enable, enabled count, both address words, data, mask and pending.
- R11: vec_cnt_o equals 1 shifted left by the stored enabled-count field. msi_en_o, msg_addr_o, msg_data_o, vec_mask_o and vec_pend_o present the stored registers.
- R12: In every writable register, byte lane k changes only when cfg_be_i[k] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe, one cycle |
| cfg_off_i | input | 8 | Byte offset from the capability base |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_off_i |
| pend_set_i | input | NUM_VEC | Set pending bits, from the dispatcher |
| pend_clr_i | input | NUM_VEC | Clear pending bits, from the dispatcher |
| msi_en_o | output | 1 | Message interrupts enabled |
| vec_cnt_o | output | 6 | Allocated vector count |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 16 | Message data |
| vec_mask_o | output | NUM_VEC | Per-vector mask |
| vec_pend_o | output | NUM_VEC | Per-vector pending |

## Verification
Two collisions matter. The dispatcher can set and clear the same pending bit in one cycle, and a control write can shrink the allocated count while pending bits sit above the new limit. The bench drives set and clear for vector 0 together and expects the bit to stay set. It then fills four pending bits, writes a smaller enabled count, and expects the bits above the new count to be gone two edges later while vector 0 remains. A further control write carries an enabled count above the supported count, and the bench expects the stored value to be clamped in that same write cycle.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  function automatic logic [31:0] be_merge(logic [31:0] old_v, logic [31:0] new_v,
                                           logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    return r;
  endfunction

  function automatic int unsigned cap_len(bit a64, bit pvm);
    case ({pvm, a64})
      2'b00:   return 'h0A;
      2'b01:   return 'h0E;
      2'b10:   return 'h14;
      default: return 'h18;
    endcase
  endfunction

  function automatic int unsigned data_dw(bit a64);
    return a64 ? 3 : 2;
  endfunction

endpackage

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
  parameter int unsigned MMC = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  output logic       en_o,
  output logic [2:0] mme_o
);
  localparam logic [2:0] MMC_V = 3'(MMC);

  logic [2:0] req;
  logic [2:0] mme_d;
  logic       unused_bits;

  assign req         = wbyte_i[6:4];
  assign mme_d       = (req > MMC_V) ? MMC_V : req;
  assign unused_bits = ^{wbyte_i[7], wbyte_i[3:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      mme_o <= '0;
    end else if (wr_i) begin
      en_o  <= wbyte_i[0];
      mme_o <= mme_d;
    end
  end
endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          PV_MASK = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_wr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  input  logic [2:0]         mme_i,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] pend_o
);
  if (PV_MASK) begin : g_mask
    logic [NUM_VEC-1:0] mask_q, pend_q, lim;
    logic [31:0]        merged;
    logic [5:0]         cnt;

    assign cnt    = 6'd1 << mme_i;
    assign merged = be_merge(32'(mask_q), wdata_i, be_i);

    always_comb
      for (int i = 0; i < NUM_VEC; i++) lim[i] = (6'(i) < cnt);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        pend_q <= '0;
      end else begin
        if (mask_wr_i) mask_q <= merged[NUM_VEC-1:0];
        // set beats clear; bits beyond the allocated count are dropped
        pend_q <= ((pend_q & ~pend_clr_i) | pend_set_i) & lim;
      end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;
  end else begin : g_nomask
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, mask_wr_i, be_i, wdata_i, mme_i,
                         pend_set_i, pend_clr_i};
    assign mask_o = '0;
    assign pend_o = '0;
  end
endmodule

// File: rtl/msi_rd_mux.sv
module msi_rd_mux
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          ADDR64  = 1,
  parameter bit          PV_MASK = 1,
  parameter int unsigned MMC     = 3
) (
  input  logic [5:0]         dw_i,
  input  logic               en_i,
  input  logic [2:0]         mme_i,
  input  logic [31:0]        addr_lo_i,
  input  logic [31:0]        addr_hi_i,
  input  logic [15:0]        data_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic [NUM_VEC-1:0] pend_i,
  output logic [31:0]        rdata_o
);
  localparam int unsigned DATA_DW = data_dw(ADDR64);
  localparam int unsigned MASK_DW = DATA_DW + 1;
  localparam int unsigned PEND_DW = DATA_DW + 2;
  localparam int unsigned WIN_DW  = (cap_len(ADDR64, PV_MASK) + 3) / 4;

  logic [15:0] ctrl;
  assign ctrl = {7'b0, PV_MASK, ADDR64, mme_i, 3'(MMC), en_i};

  always_comb begin
    rdata_o = '0;
    if (32'(dw_i) < WIN_DW) begin
      if (dw_i == 6'd0)                    rdata_o = {ctrl, 16'h0};
      else if (dw_i == 6'd1)               rdata_o = addr_lo_i;
      else if (ADDR64 && dw_i == 6'd2)     rdata_o = addr_hi_i;
      else if (32'(dw_i) == DATA_DW)       rdata_o = {16'h0, data_i};
      else if (32'(dw_i) == MASK_DW)       rdata_o = 32'(mask_i);
      else if (32'(dw_i) == PEND_DW)       rdata_o = 32'(pend_i);
    end
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          ADDR64  = 1,
  parameter bit          PV_MASK = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_off_i,
  input  logic [3:0]         cfg_be_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  output logic               msi_en_o,
  output logic [5:0]         vec_cnt_o,
  output logic [63:0]        msg_addr_o,
  output logic [15:0]        msg_data_o,
  output logic [NUM_VEC-1:0] vec_mask_o,
  output logic [NUM_VEC-1:0] vec_pend_o
);
  localparam int unsigned MMC     = $clog2(NUM_VEC);
  localparam int unsigned DATA_DW = data_dw(ADDR64);
  localparam int unsigned MASK_DW = DATA_DW + 1;

  logic [5:0]  dw;
  logic [2:0]  mme;
  logic [31:0] addr_lo_q, addr_hi;
  logic [15:0] data_q;
  logic [31:0] lo_m, data_m;
  logic        unused_off;

  assign dw         = cfg_off_i[7:2];
  assign unused_off = ^cfg_off_i[1:0];

  msi_ctrl_reg #(.MMC(MMC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_we_i && dw == 6'd0 && cfg_be_i[2]),
    .wbyte_i (cfg_wdata_i[23:16]),
    .en_o    (msi_en_o),
    .mme_o   (mme)
  );

  assign lo_m   = be_merge(addr_lo_q, cfg_wdata_i, cfg_be_i);
  assign data_m = be_merge({16'h0, data_q}, cfg_wdata_i, cfg_be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_q <= '0;
      data_q    <= '0;
    end else if (cfg_we_i) begin
      if (dw == 6'd1)                addr_lo_q <= {lo_m[31:2], 2'b00};
      if (32'(dw) == DATA_DW)        data_q    <= data_m[15:0];
    end
  end

  if (ADDR64) begin : g_hi
    logic [31:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          hi_q <= '0;
      else if (cfg_we_i && dw == 6'd2)      hi_q <= be_merge(hi_q, cfg_wdata_i, cfg_be_i);
    end
    assign addr_hi = hi_q;
  end else begin : g_nohi
    assign addr_hi = '0;
  end

  msi_vec_regs #(.NUM_VEC(NUM_VEC), .PV_MASK(PV_MASK)) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_wr_i  (cfg_we_i && 32'(dw) == MASK_DW),
    .be_i       (cfg_be_i),
    .wdata_i    (cfg_wdata_i),
    .mme_i      (mme),
    .pend_set_i (pend_set_i),
    .pend_clr_i (pend_clr_i),
    .mask_o     (vec_mask_o),
    .pend_o     (vec_pend_o)
  );

  msi_rd_mux #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .PV_MASK(PV_MASK), .MMC(MMC)) u_rd (
    .dw_i      (dw),
    .en_i      (msi_en_o),
    .mme_i     (mme),
    .addr_lo_i (addr_lo_q),
    .addr_hi_i (addr_hi),
    .data_i    (data_q),
    .mask_i    (vec_mask_o),
    .pend_i    (vec_pend_o),
    .rdata_o   (cfg_rdata_o)
  );

  assign vec_cnt_o  = 6'd1 << mme;
  assign msg_addr_o = {addr_hi, addr_lo_q};
  assign msg_data_o = data_q;
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          ADDR64  = 1,
  parameter bit          PV_MASK = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [7:0]         cfg_off_i,
  input logic [3:0]         cfg_be_i,
  input logic [31:0]        cfg_wdata_i,
  input logic [31:0]        cfg_rdata_o,
  input logic [NUM_VEC-1:0] pend_set_i,
  input logic [NUM_VEC-1:0] pend_clr_i,
  input logic               msi_en_o,
  input logic [5:0]         vec_cnt_o,
  input logic [63:0]        msg_addr_o,
  input logic [15:0]        msg_data_o,
  input logic [NUM_VEC-1:0] vec_mask_o,
  input logic [NUM_VEC-1:0] vec_pend_o
);
  localparam int unsigned WIN_DW = (cap_len(ADDR64, PV_MASK) + 3) / 4;

  logic [NUM_VEC-1:0] lim;
  logic               unused_chk;
  assign lim        = NUM_VEC'((64'd1 << vec_cnt_o) - 64'd1);
  assign unused_chk = ^{pend_clr_i, msg_data_o, vec_mask_o, cfg_be_i};

  a_r4_cnt_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(vec_cnt_o) <= NUM_VEC);

  a_r5_addr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_addr_o[1:0] == 2'b00);

  a_r5_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ADDR64 |-> msg_addr_o[63:32] == 32'h0);

  a_r3_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_off_i[7:2] == 6'd0 && cfg_be_i[2]) |=> msi_en_o == $past(cfg_wdata_i[16]));

  a_r2_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cfg_off_i[7:2]) >= WIN_DW |-> cfg_rdata_o == 32'h0);

  a_r9_pend_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (64'(vec_pend_o) >> $past(vec_cnt_o)) == 64'h0);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PV_MASK |=> ($past(pend_set_i & lim) & ~vec_pend_o) == '0);

  always @(posedge clk_i)
    if (!rst_ni)
      a_r10_reset: assert (!msi_en_o && vec_cnt_o == 6'd1 && msg_addr_o == 64'h0 &&
                           msg_data_o == 16'h0 && vec_pend_o == '0);
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .PV_MASK(PV_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_off_i(cfg_off_i),
  .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i), .msi_en_o(msi_en_o),
  .vec_cnt_o(vec_cnt_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
  .vec_mask_o(vec_mask_o), .vec_pend_o(vec_pend_o)
);

// File: tb/tb_msi_cap_regs.sv
module tb_msi_cap_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [7:0]  off = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [7:0]  pset_a = '0, pclr_a = '0;
  logic [3:0]  pset_b = '0;
  logic        en_a, en_b;
  logic [5:0]  cnt_a, cnt_b;
  logic [63:0] addr_a, addr_b;
  logic [15:0] data_a, data_b;
  logic [7:0]  mask_a, pend_a;
  logic [3:0]  mask_b, pend_b;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_cap_regs #(.NUM_VEC(8), .ADDR64(1), .PV_MASK(1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we_a), .cfg_off_i(off), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_a), .pend_set_i(pset_a), .pend_clr_i(pclr_a),
    .msi_en_o(en_a), .vec_cnt_o(cnt_a), .msg_addr_o(addr_a), .msg_data_o(data_a),
    .vec_mask_o(mask_a), .vec_pend_o(pend_a));

  msi_cap_regs #(.NUM_VEC(4), .ADDR64(0), .PV_MASK(0)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we_b), .cfg_off_i(off), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_b), .pend_set_i(pset_b), .pend_clr_i(4'h0),
    .msi_en_o(en_b), .vec_cnt_o(cnt_b), .msg_addr_o(addr_b), .msg_data_o(data_b),
    .vec_mask_o(mask_b), .vec_pend_o(pend_b));

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(int mmc, int mme, bit en, bit a64, bit pvm);
    return (32'(pvm) << 24) | (32'(a64) << 23) | (32'(mme) << 20) | (32'(mmc) << 17) | 32'(en) << 16;
  endfunction

  task automatic wr(bit to_b, logic [7:0] o, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    off = o; be = b; wdata = d;
    if (to_b) we_b = 1'b1; else we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(bit from_b, logic [7:0] o, output logic [31:0] d);
    off = o;
    #1;
    d = from_b ? rdata_b : rdata_a;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R10 en", en_a, 0);
    check("R10 cnt", cnt_a, 1);
    check("R10 addr", addr_a, 0);
    check("R10 data", data_a, 0);
    check("R10 mask", mask_a, 0);
    check("R10 pend", pend_a, 0);
    rd(0, 8'h00, r);
    check("R1 ctrl reset", r, ctrl_word(3, 0, 0, 1, 1));
  endtask

  task automatic t_ctrl;
    logic [31:0] r;
    wr(0, 8'h00, 4'b0100, 32'h0071_0000);
    check("R4 clamp cnt", cnt_a, 8);
    check("R3 en", en_a, 1);
    rd(0, 8'h00, r);
    check("R4 clamp read", r, ctrl_word(3, 3, 1, 1, 1));
    wr(0, 8'h00, 4'b1011, 32'h0000_0000);
    check("R12 ctrl no be2", en_a, 1);
    wr(0, 8'h02, 4'b1100, 32'hFFFF_FFFF);
    rd(0, 8'h00, r);
    check("R3 ro bits", r, ctrl_word(3, 3, 1, 1, 1));
    wr(0, 8'h00, 4'b0100, 32'h0010_0000);
    check("R11 cnt", cnt_a, 2);
    check("R3 en clear", en_a, 0);
  endtask

  task automatic t_addr_data;
    logic [31:0] r;
    wr(0, 8'h04, 4'b1111, 32'hDEAD_BEEF);
    check("R5 addr lo", addr_a[31:0], 32'hDEAD_BEEC);
    wr(0, 8'h08, 4'b0011, 32'h1234_5678);
    check("R12 addr hi be", addr_a[63:32], 32'h0000_5678);
    wr(0, 8'h0C, 4'b1111, 32'hABCD_1234);
    check("R6 data", data_a, 16'h1234);
    rd(0, 8'h0C, r);
    check("R6 data read", r, 32'h0000_1234);
    rd(0, 8'h07, r);
    check("R1 low offset bits", r, 32'hDEAD_BEEC);
  endtask

  task automatic t_mask;
    logic [31:0] r;
    wr(0, 8'h10, 4'b1111, 32'hFFFF_FFA5);
    check("R7 mask", mask_a, 8'hA5);
    rd(0, 8'h10, r);
    check("R7 mask read", r, 32'h0000_00A5);
    wr(0, 8'h10, 4'b1110, 32'h0000_0000);
    check("R12 mask be", mask_a, 8'hA5);
  endtask

  task automatic t_pending;
    logic [31:0] r;
    @(negedge clk); pset_a = 8'hFF;
    @(negedge clk); pset_a = 8'h00;
    check("R8 set in range", pend_a, 8'h03);
    wr(0, 8'h14, 4'b1111, 32'h0);
    check("R8 cfg write ignored", pend_a, 8'h03);
    @(negedge clk); pset_a = 8'h01; pclr_a = 8'h03;
    @(negedge clk); pset_a = 8'h00; pclr_a = 8'h00;
    check("R8 set wins", pend_a, 8'h01);
    wr(0, 8'h00, 4'b0100, 32'h0020_0000);
    @(negedge clk); pset_a = 8'h0F;
    @(negedge clk); pset_a = 8'h00;
    check("R8 set four", pend_a, 8'h0F);
    wr(0, 8'h00, 4'b0100, 32'h0000_0000);
    @(negedge clk);
    check("R9 trim", pend_a, 8'h01);
    rd(0, 8'h14, r);
    check("R1 pend read", r, 32'h1);
  endtask

  task automatic t_window;
    logic [31:0] r;
    rd(0, 8'h18, r);
    check("R2 past end", r, 0);
    rd(0, 8'hFC, r);
    check("R2 far", r, 0);
  endtask

  task automatic t_32bit;
    logic [31:0] r;
    rd(1, 8'h00, r);
    check("R1 ctrl 32", r, ctrl_word(2, 0, 0, 0, 0));
    wr(1, 8'h08, 4'b1111, 32'h5555_BEEF);
    check("R6 data 32", data_b, 16'hBEEF);
    check("R5 hi zero", addr_b[63:32], 0);
    rd(1, 8'h0C, r);
    check("R2 window 32", r, 0);
    wr(1, 8'h00, 4'b0100, 32'h0071_0000);
    check("R4 clamp 32", cnt_b, 4);
    @(negedge clk); pset_b = 4'hF;
    @(negedge clk); pset_b = 4'h0;
    check("R7 no mask pend", pend_b, 0);
    check("R7 no mask", mask_b, 0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_ctrl();
    t_addr_data();
    t_mask();
    t_pending();
    t_window();
    t_32bit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule